// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This block resolves control-transfer instructions for a machine with 64-bit instruction words and a program counter that counts instruction slots. Each accepted instruction is presented with its 8-bit operation byte, its 4-bit sub-selector field, its signed 16-bit displacement, its 32-bit immediate, the two register operands and the current PC. One clock later the block reports whether control moves, the PC of the next instruction to run, and whether the instruction was a local subroutine call (with its entry point), a platform service call, a return, or an encoding the unit does not accept.

One unit serves two comparison widths: one class compares full 64-bit operands, the other compares only their low 32 bits. Eleven relations are supported: equality, inequality, a bit-test, and signed and unsigned orderings. The unconditional jump takes its displacement from the 16-bit field in the wide class and from the 32-bit immediate in the narrow class. Call, return and service flags are raised for the surrounding pipeline, which owns the return stack, service dispatch and flushing.

The result register is organised as a small state machine whose state is the kind of the last result: `RES_NONE` (no result this cycle), `RES_FALL` (condition false), `RES_BRANCH` (jump taken), `RES_LCALL` (local call), `RES_HELPER` (service call), `RES_EXIT` (return) and `RES_BAD` (rejected encoding). In every cycle with `insn_valid` high the machine moves to the kind that the decoder computes for that instruction. In every cycle with `insn_valid` low it moves to `RES_NONE`. Reset puts it in `RES_NONE`.

Top module: `jmp_resolve_unit`

## Requirements
- R1: A result appears on the outputs in the cycle after the edge that samples `insn_valid` high, with `res_valid` high for that one cycle. In a cycle with no result, and after reset, `res_valid`, `res_taken` and all four flags are 0, and `res_next_pc` and `res_call_target` are 0.
- R2: The operation byte splits into a class in bits [2:0], a source select in bit 3 (0 = immediate, 1 = source register) and a condition code in bits [7:4]. Class 5 compares 64-bit operands and class 6 compares the low 32 bits. Any other class is rejected.
- R3: Code 0x1 is taken when the operands are equal, and code 0x5 is taken when they differ.
- R4: The unsigned relations are code 0x2 (greater), 0x3 (greater or equal), 0xa (less) and 0xb (less or equal).
- R5: The signed relations are code 0x6 (greater), 0x7 (greater or equal), 0xc (less) and 0xd (less or equal), using two's complement at the compare width.
- R6: Code 0x4 is taken when the bitwise AND of the operands at the compare width is nonzero.
- R7: In class 5 an immediate operand is sign-extended from 32 to 64 bits. In class 6 only bits [31:0] of both operands are compared, so the upper register halves have no effect on the outcome.
- R8: A taken conditional branch sets the next PC to PC + 1 + the sign-extended 16-bit displacement, modulo 2^PC_W. A branch that is not taken sets it to PC + 1.
- R9: Code 0x0 with source select 0 is always taken. In class 5 it uses the 16-bit displacement, and in class 6 it uses the 32-bit immediate as a signed displacement.
- R10: Code 0x8 in class 5 with source select 0 and sub-selector 1 is a local call. It raises `res_local_call` and `res_taken`, and sets both `res_next_pc` and `res_call_target` to PC + 1 + the sign-extended immediate.
- R11: Code 0x8 in class 5 with source select 0 and sub-selector 0 or 2 is a service call. It raises `res_helper`, leaves `res_taken` at 0 and sets the next PC to PC + 1.
- R12: Code 0x9 in class 5 with source select 0 and sub-selector 0 is a return. It raises `res_exit`, leaves `res_taken` at 0 and sets the next PC to PC + 1.
- R13: The following encodings are rejected: codes 0xe and 0xf, code 0x0 with source select 1, and codes 0x8 or 0x9 outside class 5 with source select 0 or with any other sub-selector. A rejected encoding raises `res_illegal` only, with `res_taken` 0 and next PC = PC + 1. At most one of the four flags is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction fields and operands are valid this cycle |
| insn_op | input | 8 | Operation byte: code, source select, class |
| insn_sub | input | 4 | Sub-selector field (source register number field) |
| insn_disp | input | 16 | Signed 16-bit displacement |
| insn_imm | input | 32 | 32-bit immediate |
| opnd_dst | input | 64 | Destination register value (left operand) |
| opnd_src | input | 64 | Source register value (right operand when selected) |
| cur_pc | input | PC_W | PC of the instruction, in instruction slots |
| res_valid | output | 1 | A result is presented |
| res_taken | output | 1 | Control moves to a non-sequential PC |
| res_next_pc | output | PC_W | PC of the next instruction |
| res_local_call | output | 1 | Local subroutine call |
| res_call_target | output | PC_W | Entry point of the local call, else 0 |
| res_helper | output | 1 | Platform service call |
| res_exit | output | 1 | Return |
| res_illegal | output | 1 | Encoding rejected |

## Verification
Two functions share a cycle when a new instruction is sampled on the same edge that the previous result leaves the outputs. The bench provokes this by holding `insn_valid` high for back-to-back instructions of different kinds: a taken compare followed by a service call. Each result is judged against its own instruction, with no flag or PC leaking between them. The other overlap is a local call, which must raise the redirect and the call flag together, with matching PC and target. Its check compares both outputs in the same sample.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int unsigned OP_W   = 8;
    localparam int unsigned SUB_W  = 4;
    localparam int unsigned DISP_W = 16;
    localparam int unsigned IMM_W  = 32;

    localparam logic [2:0] CLS_WIDE   = 3'h5;
    localparam logic [2:0] CLS_NARROW = 3'h6;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'h0,
        CC_EQ     = 4'h1,
        CC_UGT    = 4'h2,
        CC_UGE    = 4'h3,
        CC_ANY    = 4'h4,
        CC_NE     = 4'h5,
        CC_SGT    = 4'h6,
        CC_SGE    = 4'h7,
        CC_CALL   = 4'h8,
        CC_RET    = 4'h9,
        CC_ULT    = 4'ha,
        CC_ULE    = 4'hb,
        CC_SLT    = 4'hc,
        CC_SLE    = 4'hd
    } brc_code_e;

    typedef enum logic [2:0] {
        RES_NONE,
        RES_FALL,
        RES_BRANCH,
        RES_LCALL,
        RES_HELPER,
        RES_EXIT,
        RES_BAD
    } brc_res_e;

endpackage

// File: rtl/brc_operands.sv
module brc_operands #(
    parameter int unsigned XLEN = 64
) (
    input  logic                       use_reg,
    input  logic [brc_pkg::IMM_W-1:0]  imm,
    input  logic [XLEN-1:0]            dst_val,
    input  logic [XLEN-1:0]            src_val,
    output logic [XLEN-1:0]            lhs,
    output logic [XLEN-1:0]            rhs
);
    logic [XLEN-1:0] imm_wide;

    always_comb begin
        imm_wide = XLEN'($signed(imm));
        lhs      = dst_val;
        rhs      = use_reg ? src_val : imm_wide;
    end
endmodule

// File: rtl/brc_cmp.sv
module brc_cmp #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0]        lhs,
    input  logic [W-1:0]        rhs,
    input  brc_pkg::brc_code_e  code,
    output logic                hit
);
    import brc_pkg::*;

    logic eq_w;
    logic ult_w;
    logic slt_w;
    logic any_w;

    always_comb begin
        eq_w  = (lhs == rhs);
        ult_w = (lhs < rhs);
        slt_w = ($signed(lhs) < $signed(rhs));
        any_w = |(lhs & rhs);
        unique case (code)
            CC_EQ:   hit = eq_w;
            CC_NE:   hit = !eq_w;
            CC_UGT:  hit = !ult_w && !eq_w;
            CC_UGE:  hit = !ult_w;
            CC_ULT:  hit = ult_w;
            CC_ULE:  hit = ult_w || eq_w;
            CC_SGT:  hit = !slt_w && !eq_w;
            CC_SGE:  hit = !slt_w;
            CC_SLT:  hit = slt_w;
            CC_SLE:  hit = slt_w || eq_w;
            CC_ANY:  hit = any_w;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brc_decode.sv
module brc_decode (
    input  logic [brc_pkg::OP_W-1:0]   op,
    input  logic [brc_pkg::SUB_W-1:0]  sub,
    input  logic                       hit_wide,
    input  logic                       hit_narrow,
    output brc_pkg::brc_res_e          kind,
    output logic                       disp_from_imm
);
    import brc_pkg::*;

    logic      is_wide;
    logic      is_narrow;
    logic      use_reg;
    logic      hit_sel;
    brc_code_e code;

    always_comb begin
        is_wide       = (op[2:0] == CLS_WIDE);
        is_narrow     = (op[2:0] == CLS_NARROW);
        use_reg       = op[3];
        code          = brc_code_e'(op[7:4]);
        hit_sel       = is_narrow ? hit_narrow : hit_wide;
        kind          = RES_BAD;
        disp_from_imm = 1'b0;
        if (is_wide || is_narrow) begin
            unique case (code)
                CC_ALWAYS: begin
                    if (!use_reg) begin
                        kind          = RES_BRANCH;
                        disp_from_imm = is_narrow;
                    end
                end
                CC_CALL: begin
                    if (is_wide && !use_reg) begin
                        unique case (sub)
                            4'd0, 4'd2: kind = RES_HELPER;
                            4'd1:       kind = RES_LCALL;
                            default:    kind = RES_BAD;
                        endcase
                    end
                end
                CC_RET: begin
                    if (is_wide && !use_reg && sub == '0) begin
                        kind = RES_EXIT;
                    end
                end
                CC_EQ, CC_NE, CC_UGT, CC_UGE, CC_ULT, CC_ULE,
                CC_SGT, CC_SGE, CC_SLT, CC_SLE, CC_ANY: begin
                    kind = hit_sel ? RES_BRANCH : RES_FALL;
                end
                default: kind = RES_BAD;
            endcase
        end
    end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0]             pc,
    input  logic [brc_pkg::DISP_W-1:0]  disp,
    input  logic [brc_pkg::IMM_W-1:0]   imm,
    input  logic                        disp_from_imm,
    output logic [PC_W-1:0]             seq_pc,
    output logic [PC_W-1:0]             jump_pc,
    output logic [PC_W-1:0]             call_pc
);
    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] imm_ext;

    always_comb begin
        disp_ext = PC_W'($signed(disp));
        imm_ext  = PC_W'($signed(imm));
        seq_pc   = pc + PC_W'(1);
        jump_pc  = seq_pc + (disp_from_imm ? imm_ext : disp_ext);
        call_pc  = seq_pc + imm_ext;
    end
endmodule

// File: rtl/jmp_resolve_unit.sv
module jmp_resolve_unit #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned PC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  logic [7:0]       insn_op,
    input  logic [3:0]       insn_sub,
    input  logic [15:0]      insn_disp,
    input  logic [31:0]      insn_imm,
    input  logic [XLEN-1:0]  opnd_dst,
    input  logic [XLEN-1:0]  opnd_src,
    input  logic [PC_W-1:0]  cur_pc,
    output logic             res_valid,
    output logic             res_taken,
    output logic [PC_W-1:0]  res_next_pc,
    output logic             res_local_call,
    output logic [PC_W-1:0]  res_call_target,
    output logic             res_helper,
    output logic             res_exit,
    output logic             res_illegal
);
    import brc_pkg::*;

    localparam int unsigned HALF   = XLEN / 2;
    localparam int unsigned N_CMP  = 2;

    logic [XLEN-1:0]  op_lhs;
    logic [XLEN-1:0]  op_rhs;
    logic [N_CMP-1:0] hits;
    brc_code_e        code;
    brc_res_e         kind_d;
    logic             disp_from_imm;
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  jump_pc;
    logic [PC_W-1:0]  call_pc;

    brc_res_e         res_q;
    logic [PC_W-1:0]  npc_q;
    logic [PC_W-1:0]  tgt_q;

    assign code = brc_code_e'(insn_op[7:4]);

    brc_operands #(.XLEN(XLEN)) u_opnd (
        .use_reg (insn_op[3]),
        .imm     (insn_imm),
        .dst_val (opnd_dst),
        .src_val (opnd_src),
        .lhs     (op_lhs),
        .rhs     (op_rhs)
    );

    // index 0 compares the full width, index 1 the low half
    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
        localparam int unsigned CW = (gi == 0) ? XLEN : HALF;
        brc_cmp #(.W(CW)) u_cmp (
            .lhs  (op_lhs[CW-1:0]),
            .rhs  (op_rhs[CW-1:0]),
            .code (code),
            .hit  (hits[gi])
        );
    end

    brc_decode u_dec (
        .op            (insn_op),
        .sub           (insn_sub),
        .hit_wide      (hits[0]),
        .hit_narrow    (hits[1]),
        .kind          (kind_d),
        .disp_from_imm (disp_from_imm)
    );

    brc_target #(.PC_W(PC_W)) u_tgt (
        .pc            (cur_pc),
        .disp          (insn_disp),
        .imm           (insn_imm),
        .disp_from_imm (disp_from_imm),
        .seq_pc        (seq_pc),
        .jump_pc       (jump_pc),
        .call_pc       (call_pc)
    );

    // state register: kind of the result being presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= RES_NONE;
            npc_q <= '0;
            tgt_q <= '0;
        end else if (!insn_valid) begin
            res_q <= RES_NONE;
            npc_q <= '0;
            tgt_q <= '0;
        end else begin
            res_q <= kind_d;
            tgt_q <= '0;
            unique case (kind_d)
                RES_BRANCH: npc_q <= jump_pc;
                RES_LCALL: begin
                    npc_q <= call_pc;
                    tgt_q <= call_pc;
                end
                default:    npc_q <= seq_pc;
            endcase
        end
    end

    // output process
    always_comb begin
        res_valid       = 1'b1;
        res_taken       = 1'b0;
        res_local_call  = 1'b0;
        res_helper      = 1'b0;
        res_exit        = 1'b0;
        res_illegal     = 1'b0;
        res_next_pc     = npc_q;
        res_call_target = tgt_q;
        unique case (res_q)
            RES_NONE:   res_valid = 1'b0;
            RES_FALL:   ;
            RES_BRANCH: res_taken = 1'b1;
            RES_LCALL: begin
                res_taken      = 1'b1;
                res_local_call = 1'b1;
            end
            RES_HELPER: res_helper  = 1'b1;
            RES_EXIT:   res_exit    = 1'b1;
            RES_BAD:    res_illegal = 1'b1;
            default:    res_valid   = 1'b0;
        endcase
    end

    // R1
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> res_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> (!res_valid && !res_taken && res_next_pc == '0
                         && res_call_target == '0));
    // R2
    bad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op[2:0] != CLS_WIDE && insn_op[2:0] != CLS_NARROW)
        |=> res_illegal);
    // R3
    eq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op == 8'h1D && opnd_dst == opnd_src) |=> res_taken);
    // R8
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> (res_taken || res_next_pc == $past(cur_pc) + PC_W'(1)));
    // R9
    always_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op[7:3] == 5'b0 &&
         (insn_op[2:0] == CLS_WIDE || insn_op[2:0] == CLS_NARROW))
        |=> (res_taken && !res_illegal));
    // R10
    lcall_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_local_call |-> (res_taken && res_next_pc == res_call_target));
    // R11
    helper_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_helper || res_exit) |-> !res_taken);
    // R13
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_local_call, res_helper, res_exit, res_illegal}));
    // R13
    illegal_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (!res_taken && res_valid));

endmodule

// File: tb/jmp_resolve_unit_tb_top.sv
`timescale 1ns/1ps
module jmp_resolve_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [7:0]  insn_op = '0;
    logic [3:0]  insn_sub = '0;
    logic [15:0] insn_disp = '0;
    logic [31:0] insn_imm = '0;
    logic [63:0] opnd_dst = '0;
    logic [63:0] opnd_src = '0;
    logic [31:0] cur_pc = '0;
    logic        res_valid, res_taken, res_local_call, res_helper, res_exit, res_illegal;
    logic [31:0] res_next_pc, res_call_target;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // flag encodings for expectations: {local_call, helper, exit, illegal}
    localparam logic [3:0] F_NONE = 4'b0000;
    localparam logic [3:0] F_LC   = 4'b1000;
    localparam logic [3:0] F_HLP  = 4'b0100;
    localparam logic [3:0] F_EXT  = 4'b0010;
    localparam logic [3:0] F_BAD  = 4'b0001;

    always #5 clk = ~clk;

    jmp_resolve_unit dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_op(insn_op),
        .insn_sub(insn_sub), .insn_disp(insn_disp), .insn_imm(insn_imm),
        .opnd_dst(opnd_dst), .opnd_src(opnd_src), .cur_pc(cur_pc),
        .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
        .res_local_call(res_local_call), .res_call_target(res_call_target),
        .res_helper(res_helper), .res_exit(res_exit), .res_illegal(res_illegal)
    );

    function automatic logic [7:0] op(input logic [3:0] code, input logic s, input logic [2:0] cls);
        return {code, s, cls};
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic drive(input logic [7:0] o, input logic [3:0] sb, input logic [15:0] d,
                         input logic [31:0] im, input logic [63:0] a, input logic [63:0] b,
                         input logic [31:0] pc);
        insn_valid = 1'b1; insn_op = o; insn_sub = sb; insn_disp = d;
        insn_imm = im; opnd_dst = a; opnd_src = b; cur_pc = pc;
    endtask

    task automatic expect_out(input string tag, input logic exp_v, input logic exp_t,
                              input logic [31:0] exp_pc, input logic [3:0] exp_f,
                              input logic [31:0] exp_tgt);
        logic [3:0] act_f;
        act_f = {res_local_call, res_helper, res_exit, res_illegal};
        checks++;
        if (res_valid !== exp_v || res_taken !== exp_t || res_next_pc !== exp_pc ||
            act_f !== exp_f || res_call_target !== exp_tgt) begin
            fails++;
            $display("FAIL %s: actual v=%0b t=%0b pc=%h f=%b tgt=%h expected v=%0b t=%0b pc=%h f=%b tgt=%h",
                     tag, res_valid, res_taken, res_next_pc, act_f, res_call_target,
                     exp_v, exp_t, exp_pc, exp_f, exp_tgt);
        end
    endtask

    // one instruction: drive at negedge, sample the registered result at the next negedge
    task automatic one(input string tag, input logic [7:0] o, input logic [3:0] sb,
                       input logic [15:0] d, input logic [31:0] im, input logic [63:0] a,
                       input logic [63:0] b, input logic [31:0] pc,
                       input logic exp_t, input logic [31:0] exp_pc, input logic [3:0] exp_f,
                       input logic [31:0] exp_tgt);
        @(negedge clk);
        drive(o, sb, d, im, a, b, pc);
        @(negedge clk);
        insn_valid = 1'b0;
        expect_out(tag, 1'b1, exp_t, exp_pc, exp_f, exp_tgt);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_out("R1 reset state", 1'b0, 1'b0, 32'h0, F_NONE, 32'h0);
    endtask

    task automatic t_equality();
        one("R3 eq reg equal", op(4'h1,1,3'h5), 4'h3, 16'd5, 32'h0,
            64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 32'd100, 1, 32'd106, F_NONE, 0);
        one("R3 eq reg differ high", op(4'h1,1,3'h5), 4'h0, 16'd5, 32'h0,
            64'h1_0000_0005, 64'h5, 32'd100, 0, 32'd101, F_NONE, 0);
        one("R7 narrow eq ignores upper", op(4'h1,1,3'h6), 4'h0, 16'd5, 32'h0,
            64'h1_0000_0005, 64'h5, 32'd100, 1, 32'd106, F_NONE, 0);
        one("R7 R3 ne imm sign-extended", op(4'h5,0,3'h5), 4'h0, 16'd9, 32'hFFFF_FFFF,
            64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'd40, 0, 32'd41, F_NONE, 0);
        one("R3 ne imm differs", op(4'h5,0,3'h5), 4'h0, 16'd9, 32'h0000_0007,
            64'h8, 64'h0, 32'd40, 1, 32'd50, F_NONE, 0);
    endtask

    task automatic t_unsigned();
        one("R4 ugt msb set", op(4'h2,1,3'h5), 4'h0, 16'd2, 0,
            64'h8000_0000_0000_0000, 64'h1, 32'd10, 1, 32'd13, F_NONE, 0);
        one("R4 uge equal", op(4'h3,1,3'h5), 4'h0, 16'd2, 0, 64'h77, 64'h77, 32'd10, 1, 32'd13, F_NONE, 0);
        one("R4 ugt equal not taken", op(4'h2,1,3'h5), 4'h0, 16'd2, 0, 64'h77, 64'h77, 32'd10, 0, 32'd11, F_NONE, 0);
        one("R4 ult", op(4'ha,1,3'h5), 4'h0, 16'd2, 0, 64'h1, 64'h2, 32'd10, 1, 32'd13, F_NONE, 0);
        one("R4 ule greater not taken", op(4'hb,1,3'h5), 4'h0, 16'd2, 0, 64'h3, 64'h2, 32'd10, 0, 32'd11, F_NONE, 0);
        one("R4 ule equal", op(4'hb,1,3'h5), 4'h0, 16'd2, 0, 64'h2, 64'h2, 32'd10, 1, 32'd13, F_NONE, 0);
    endtask

    task automatic t_signed();
        one("R5 sgt negative not taken", op(4'h6,1,3'h5), 4'h0, 16'd4, 0,
            64'h8000_0000_0000_0000, 64'h1, 32'd10, 0, 32'd11, F_NONE, 0);
        one("R5 sge equal negatives", op(4'h7,1,3'h5), 4'h0, 16'd4, 0,
            64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'd10, 1, 32'd15, F_NONE, 0);
        one("R5 slt", op(4'hc,1,3'h5), 4'h0, 16'd4, 0,
            64'hFFFF_FFFF_FFFF_FFFB, 64'h3, 32'd10, 1, 32'd15, F_NONE, 0);
        one("R5 sle not taken", op(4'hd,1,3'h5), 4'h0, 16'd4, 0,
            64'h3, 64'hFFFF_FFFF_FFFF_FFFB, 32'd10, 0, 32'd11, F_NONE, 0);
        one("R5 R7 narrow sgt s32 negative", op(4'h6,1,3'h6), 4'h0, 16'd4, 0,
            64'h0000_0000_8000_0000, 64'h1, 32'd10, 0, 32'd11, F_NONE, 0);
        one("R5 wide sgt same operands", op(4'h6,1,3'h5), 4'h0, 16'd4, 0,
            64'h0000_0000_8000_0000, 64'h1, 32'd10, 1, 32'd15, F_NONE, 0);
        one("R5 narrow slt imm", op(4'hc,0,3'h6), 4'h0, 16'd4, 32'hFFFF_FFFF,
            64'h5_FFFF_FFFE, 64'h0, 32'd10, 1, 32'd15, F_NONE, 0);
    endtask

    task automatic t_bittest();
        one("R6 any disjoint", op(4'h4,1,3'h5), 4'h0, 16'd1, 0, 64'hF0, 64'h0F, 32'd7, 0, 32'd8, F_NONE, 0);
        one("R6 any overlap", op(4'h4,1,3'h5), 4'h0, 16'd1, 0, 64'hF0, 64'h10, 32'd7, 1, 32'd9, F_NONE, 0);
        one("R6 R7 narrow any upper only", op(4'h4,0,3'h6), 4'h0, 16'd1, 32'hFFFF_FFFF,
            64'h1_0000_0000, 64'h0, 32'd7, 0, 32'd8, F_NONE, 0);
        one("R6 R7 wide any sign-extended imm", op(4'h4,0,3'h5), 4'h0, 16'd1, 32'hFFFF_FFFF,
            64'h1_0000_0000, 64'h0, 32'd7, 1, 32'd9, F_NONE, 0);
    endtask

    task automatic t_offsets();
        one("R8 negative disp", op(4'h1,1,3'h5), 4'h0, 16'hFFFD, 0, 64'h0, 64'h0, 32'd10, 1, 32'd8, F_NONE, 0);
        one("R8 wrap below zero", op(4'h1,1,3'h5), 4'h0, 16'hFFFD, 0, 64'h0, 64'h0, 32'd0, 1, 32'hFFFF_FFFE, F_NONE, 0);
        one("R8 max positive disp", op(4'h1,1,3'h5), 4'h0, 16'h7FFF, 0, 64'h0, 64'h0, 32'd0, 1, 32'h0000_8000, F_NONE, 0);
    endtask

    task automatic t_uncond();
        one("R9 wide uses disp", op(4'h0,0,3'h5), 4'h0, 16'd7, 32'd1000, 64'h0, 64'h0, 32'd20, 1, 32'd28, F_NONE, 0);
        one("R9 narrow uses imm", op(4'h0,0,3'h6), 4'h0, 16'd7, 32'd1000, 64'h0, 64'h0, 32'd20, 1, 32'd1021, F_NONE, 0);
        one("R9 narrow negative imm", op(4'h0,0,3'h6), 4'h0, 16'd7, 32'hFFFF_FF00, 64'h0, 64'h0, 32'd500, 1, 32'd245, F_NONE, 0);
    endtask

    task automatic t_calls();
        one("R10 local call", op(4'h8,0,3'h5), 4'h1, 16'd3, 32'd40, 64'h0, 64'h0, 32'd50, 1, 32'd91, F_LC, 32'd91);
        one("R10 local call backward", op(4'h8,0,3'h5), 4'h1, 16'd3, 32'hFFFF_FFF6, 64'h0, 64'h0, 32'd50, 1, 32'd41, F_LC, 32'd41);
        one("R11 service sub 0", op(4'h8,0,3'h5), 4'h0, 16'd3, 32'd40, 64'h0, 64'h0, 32'd50, 0, 32'd51, F_HLP, 0);
        one("R11 service sub 2", op(4'h8,0,3'h5), 4'h2, 16'd3, 32'd40, 64'h0, 64'h0, 32'd50, 0, 32'd51, F_HLP, 0);
    endtask

    task automatic t_exit();
        one("R12 return", op(4'h9,0,3'h5), 4'h0, 16'd3, 32'd40, 64'h0, 64'h0, 32'd60, 0, 32'd61, F_EXT, 0);
    endtask

    task automatic t_illegal();
        one("R13 call sub 3", op(4'h8,0,3'h5), 4'h3, 0, 32'd40, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R13 call narrow class", op(4'h8,0,3'h6), 4'h1, 0, 32'd40, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R13 call reg source", op(4'h8,1,3'h5), 4'h1, 0, 32'd40, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R13 return sub 1", op(4'h9,0,3'h5), 4'h1, 0, 0, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R13 return narrow", op(4'h9,0,3'h6), 4'h0, 0, 0, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R13 always with reg", op(4'h0,1,3'h5), 4'h0, 16'd7, 0, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R13 code e", op(4'he,0,3'h5), 4'h0, 16'd7, 0, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R13 code f narrow", op(4'hf,1,3'h6), 4'h0, 16'd7, 0, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
        one("R2 non-jump class", op(4'h1,1,3'h4), 4'h0, 16'd7, 0, 0, 0, 32'd5, 0, 32'd6, F_BAD, 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(op(4'h1,1,3'h5), 4'h0, 16'd4, 0, 64'h9, 64'h9, 32'd200);
        @(negedge clk);
        expect_out("R1 R3 back-to-back first", 1'b1, 1'b1, 32'd205, F_NONE, 0);
        drive(op(4'h8,0,3'h5), 4'h2, 16'd4, 32'd77, 64'h9, 64'h9, 32'd300);
        @(negedge clk);
        insn_valid = 1'b0;
        expect_out("R1 R11 back-to-back second", 1'b1, 1'b0, 32'd301, F_HLP, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        expect_out("R1 idle after result", 1'b0, 1'b0, 32'h0, F_NONE, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_equality();
        t_unsigned();
        t_signed();
        t_bittest();
        t_offsets();
        t_uncond();
        t_calls();
        t_idle();
        t_exit();
        t_illegal();
        t_back_to_back();
        t_idle();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule